// File: doc/BRIEF.md
# Next-PC Unit

This block holds the program counter of a simple 16-bit processor and decides, once per executed instruction, where the next instruction comes from. The surrounding pipeline presents the instruction word, the current negative/zero/positive condition flags and the value of the register that the instruction's base field selects, and pulses `step` for one clock to commit that instruction. The block then picks one of three sources for the new PC: the incremented PC, the output of a single target adder (PC-relative or base-register), or a word read back from a vector table in memory.

Conditional branches are resolved by masking the instruction's three condition-select bits against the flags, so no comparator is involved. Subroutine calls and traps also produce a return-address write for link register R7, presented on a write strobe with its data. A trap takes two phases: in the committing cycle the block issues a vector-table read request, and it waits until the memory returns valid data before loading the PC. While it waits, further steps are ignored.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes `RESET_PC` (default 0x3000), `trap_wait` is 0, and in the cycle after reset `link_we` and `vec_req` are 0 while `step` is 0.
- R2: With `step` low and no trap pending, the PC keeps its value at every clock edge.
- R3: A committed instruction whose opcode (bits 15:12) is none of 0000, 0100, 1100, 1111 sets the PC to PC+1.
- R4: Opcode 0000 is a conditional branch. Bit 11 selects the negative flag, bit 10 the zero flag, bit 9 the positive flag. If any selected bit meets a set flag, the PC becomes PC+1+sign-extended bits 8:0; otherwise it becomes PC+1, so a branch with bits 11:9 all zero never redirects.
- R5: Opcode 1100 is a jump: the PC becomes `base_val`.
- R6: Opcode 0100 is a call. When bit 11 is 1 the PC becomes PC+1+sign-extended bits 10:0; when bit 11 is 0 the PC becomes `base_val`. In the committing cycle `link_we` is 1 and `link_data` is PC+1.
- R7: Opcode 1111 is a trap. In the committing cycle `vec_req` is 1, `vec_raddr` is bits 7:0 zero-extended, `link_we` is 1 with `link_data` = PC+1; the PC does not change at that edge and `trap_wait` becomes 1.
- R8: While `trap_wait` is 1, `step` is ignored (no PC change, no `link_we`, no `vec_req`); at the first edge with `vec_rvalid` high the PC takes `vec_rdata` and `trap_wait` returns to 0. `vec_rvalid` is ignored when no trap is pending.
- R9: All PC and target arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Commit the presented instruction this cycle |
| instr | input | 16 | Instruction word being committed |
| flag_n | input | 1 | Negative condition flag |
| flag_z | input | 1 | Zero condition flag |
| flag_p | input | 1 | Positive condition flag |
| base_val | input | 16 | Contents of the register named by bits 8:6 |
| vec_rdata | input | 16 | Vector-table read data |
| vec_rvalid | input | 1 | Vector-table read data valid |
| pc | output | 16 | Current program counter |
| vec_req | output | 1 | Vector-table read request (one cycle) |
| vec_raddr | output | 16 | Vector-table read address |
| trap_wait | output | 1 | A trap is waiting for its vector word |
| link_we | output | 1 | Write strobe for link register R7 |
| link_data | output | 16 | Return address for R7 |

## Verification
The bench aims at branches whose select bits are all clear while every flag is set, which a design that treated an empty mask as "always" would take, and at single-flag branches where only the matching flag decides the outcome. Jumps and calls near the top of the address space and a call with the most negative long offset expose adders that saturate or drop the carry instead of wrapping. Traps are hit with read data arriving in the request cycle itself, with steps presented during the wait, and with long waits, so a design that loaded the PC early, accepted a second instruction, or repeated the link write or request would diverge from the model. Constrained random traffic over all opcodes and flag patterns then covers the remaining combinations.

// File: rtl/npc_pkg.sv
// Package npc_pkg
// Shared constants and types for the next-PC unit. Assumes a 16-bit
// instruction word with the opcode in its top four bits.
package npc_pkg;

    localparam int IW = 16;          // instruction width
    localparam int OPC_LSB = 12;     // opcode field low bit
    localparam int COND_LSB = 9;     // condition-select field low bit (p,z,n upward)
    localparam int NUM_FLAGS = 3;

    localparam logic [3:0] OPC_BRANCH = 4'b0000;
    localparam logic [3:0] OPC_CALL   = 4'b0100;
    localparam logic [3:0] OPC_JUMP   = 4'b1100;
    localparam logic [3:0] OPC_TRAP   = 4'b1111;

    // Source chosen by the next-PC selector
    typedef enum logic [1:0] {
        SRC_INC = 2'd0,
        SRC_ADD = 2'd1,
        SRC_VEC = 2'd2
    } pc_src_e;

    // Decoded control for one instruction
    typedef struct packed {
        logic redirect;   // PC takes the target adder output
        logic use_base;   // adder uses the base register with zero offset
        logic long_off;   // adder uses the long (call) offset
        logic link;       // write return address to R7
        logic trap;       // start the vector-table read
    } npc_ctl_t;

endpackage

// File: rtl/npc_decode.sv
// Module npc_decode
// Classifies the upper bits of the instruction and resolves conditional
// branches by masking the select bits against the flags. Purely
// combinational; assumes flags[2]=negative, flags[1]=zero, flags[0]=positive,
// lined up with select bits 11, 10, 9.
module npc_decode
    import npc_pkg::*;
(
    input  logic [IW-1:COND_LSB]  instr_hi,
    input  logic [NUM_FLAGS-1:0]  flags,
    output npc_ctl_t              ctl
);

    logic [3:0]           opcode;
    logic [NUM_FLAGS-1:0] cond_hit;
    logic                 cond_taken;

    assign opcode = instr_hi[IW-1:OPC_LSB];

    // one AND per flag: a select bit only counts when its flag is set
    genvar gi;
    generate
        for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_cond
            assign cond_hit[gi] = instr_hi[COND_LSB+gi] & flags[gi];
        end
    endgenerate

    assign cond_taken = |cond_hit;

    // Purpose: map opcode (and branch outcome) onto control bits
    always_comb begin
        ctl = '0;
        case (opcode)
            OPC_BRANCH: begin
                ctl.redirect = cond_taken;
            end
            OPC_JUMP: begin
                ctl.redirect = 1'b1;
                ctl.use_base = 1'b1;
            end
            OPC_CALL: begin
                ctl.redirect = 1'b1;
                ctl.link     = 1'b1;
                ctl.long_off = instr_hi[11];
                ctl.use_base = ~instr_hi[11];
            end
            OPC_TRAP: begin
                ctl.trap = 1'b1;
                ctl.link = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
// Module npc_target
// The single target adder. Adds either the short or long sign-extended
// offset to the incremented PC, or adds zero to the base register value.
// Assumes XLEN is larger than LONG_OFF, and that the result wraps.
module npc_target #(
    parameter int XLEN      = 16,
    parameter int SHORT_OFF = 9,
    parameter int LONG_OFF  = 11
) (
    input  logic [XLEN-1:0]     pc_inc,
    input  logic [XLEN-1:0]     base_val,
    input  logic [LONG_OFF-1:0] off_field,
    input  logic                use_base,
    input  logic                long_off,
    output logic [XLEN-1:0]     target
);

    localparam int SHORT_PAD = XLEN - SHORT_OFF;
    localparam int LONG_PAD  = XLEN - LONG_OFF;

    logic [XLEN-1:0] sext_short;
    logic [XLEN-1:0] sext_long;
    logic [XLEN-1:0] add_a;
    logic [XLEN-1:0] add_b;

    assign sext_short = {{SHORT_PAD{off_field[SHORT_OFF-1]}}, off_field[SHORT_OFF-1:0]};
    assign sext_long  = {{LONG_PAD{off_field[LONG_OFF-1]}}, off_field};

    // Purpose: choose adder operands for the current control form
    always_comb begin
        if (use_base) begin
            add_a = base_val;
            add_b = '0;
        end else begin
            add_a = pc_inc;
            add_b = long_off ? sext_long : sext_short;
        end
    end

    assign target = add_a + add_b;

endmodule

// File: rtl/npc_trap_seq.sv
// Module npc_trap_seq
// Two-state sequencer for the trap path. A start pulse moves it into the
// waiting state; the first valid read word produces a one-cycle load and
// returns it to idle. Assumes start is only raised while idle.
module npc_trap_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rvalid,
    output logic waiting,
    output logic load
);

    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} trap_st_e;

    trap_st_e state_q;

    assign waiting = (state_q == ST_WAIT);
    assign load    = waiting & rvalid;

    // Purpose: track whether a vector word is outstanding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start) state_q <= ST_WAIT;
                ST_WAIT: if (rvalid) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7: a request always leads into the waiting state
    a_r7_enter_wait: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> waiting);

    // R8: valid data ends the wait at the next edge
    a_r8_leave_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rvalid) |=> !waiting);

    // R8: without valid data the wait persists
    a_r8_keep_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !rvalid) |=> waiting);

endmodule

// File: rtl/npc_unit.sv
// Module npc_unit
// Program counter register and next-PC selection. Each step commits one
// instruction; a three-way selector picks incremented PC, target adder
// output or vector-table word. Assumes base_val already holds the register
// named by instr[8:6] and that the vector memory answers with vec_rvalid.
module npc_unit
    import npc_pkg::*;
#(
    parameter int          XLEN      = 16,
    parameter int          SHORT_OFF = 9,
    parameter int          LONG_OFF  = 11,
    parameter int          VEC_W     = 8,
    parameter logic [15:0] RESET_PC  = 16'h3000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic [IW-1:0]   instr,
    input  logic            flag_n,
    input  logic            flag_z,
    input  logic            flag_p,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] vec_rdata,
    input  logic            vec_rvalid,
    output logic [XLEN-1:0] pc,
    output logic            vec_req,
    output logic [XLEN-1:0] vec_raddr,
    output logic            trap_wait,
    output logic            link_we,
    output logic [XLEN-1:0] link_data
);

    localparam int VEC_PAD = XLEN - VEC_W;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_inc;
    logic [XLEN-1:0] pc_d;
    logic [XLEN-1:0] target;
    logic            pc_en;
    logic            accept;
    logic            vec_load;
    npc_ctl_t        ctl;
    pc_src_e         pc_src;

    assign pc_inc = pc_q + 1'b1;
    assign accept = step & ~trap_wait;

    npc_decode u_decode (
        .instr_hi (instr[IW-1:COND_LSB]),
        .flags    ({flag_n, flag_z, flag_p}),
        .ctl      (ctl)
    );

    npc_target #(
        .XLEN      (XLEN),
        .SHORT_OFF (SHORT_OFF),
        .LONG_OFF  (LONG_OFF)
    ) u_target (
        .pc_inc    (pc_inc),
        .base_val  (base_val),
        .off_field (instr[LONG_OFF-1:0]),
        .use_base  (ctl.use_base),
        .long_off  (ctl.long_off),
        .target    (target)
    );

    npc_trap_seq u_trap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (vec_req),
        .rvalid  (vec_rvalid),
        .waiting (trap_wait),
        .load    (vec_load)
    );

    // Purpose: choose the PC source and whether the PC updates this cycle
    always_comb begin
        pc_src = SRC_INC;
        pc_en  = 1'b0;
        if (vec_load) begin
            pc_src = SRC_VEC;
            pc_en  = 1'b1;
        end else if (accept && !ctl.trap) begin
            pc_src = ctl.redirect ? SRC_ADD : SRC_INC;
            pc_en  = 1'b1;
        end
    end

    // Purpose: three-way next-PC selector
    always_comb begin
        case (pc_src)
            SRC_ADD: pc_d = target;
            SRC_VEC: pc_d = vec_rdata;
            default: pc_d = pc_inc;
        endcase
    end

    // Purpose: program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC[XLEN-1:0];
        end else if (pc_en) begin
            pc_q <= pc_d;
        end
    end

    assign pc        = pc_q;
    assign vec_req   = accept & ctl.trap;
    assign vec_raddr = {{VEC_PAD{1'b0}}, instr[VEC_W-1:0]};
    assign link_we   = accept & ctl.link;
    assign link_data = pc_inc;

    // R1: the cycle after reset shows the reset PC and no pending trap
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pc == RESET_PC[XLEN-1:0]) && !trap_wait);

    // R2: an idle cycle leaves the PC alone
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !trap_wait) |=> $stable(pc));

    // R3: non-control opcodes advance by one
    a_r3_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !trap_wait && instr[15:12] != OPC_BRANCH && instr[15:12] != OPC_CALL
         && instr[15:12] != OPC_JUMP && instr[15:12] != OPC_TRAP)
        |=> pc == $past(pc) + 1'b1);

    // R4: an empty select mask never redirects
    a_r4_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !trap_wait && instr[15:12] == OPC_BRANCH && instr[11:9] == 3'b000)
        |=> pc == $past(pc) + 1'b1);

    // R5: a jump lands on the base register value
    a_r5_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !trap_wait && instr[15:12] == OPC_JUMP) |=> pc == $past(base_val));

    // R6: the return address is the incremented PC
    a_r6_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> link_data == pc + 1'b1);

    // R7: a trap commit does not move the PC
    a_r7_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> $stable(pc));

    // R8: steps during the wait are ignored and the PC holds until data
    a_r8_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
        trap_wait |-> !link_we && !vec_req);

    a_r8_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_wait && !vec_rvalid) |=> $stable(pc));

    a_r8_vec_load: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_wait && vec_rvalid) |=> pc == $past(vec_rdata));

endmodule

// File: tb/test_npc_unit.sv
// Bench for npc_unit: directed corner cases followed by seeded random
// traffic, checked against a cycle model computed from the requirements.
module test_npc_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step;
    logic [15:0] instr;
    logic        flag_n, flag_z, flag_p;
    logic [15:0] base_val;
    logic [15:0] vec_rdata;
    logic        vec_rvalid;
    logic [15:0] pc;
    logic        vec_req;
    logic [15:0] vec_raddr;
    logic        trap_wait;
    logic        link_we;
    logic [15:0] link_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] m_pc;
    logic        m_wait;
    string       m_tag;

    always #2 clk = ~clk;   // 250 MHz

    npc_unit i_npc_unit (
        .clk(clk), .rst_n(rst_n), .step(step), .instr(instr),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
        .base_val(base_val), .vec_rdata(vec_rdata), .vec_rvalid(vec_rvalid),
        .pc(pc), .vec_req(vec_req), .vec_raddr(vec_raddr), .trap_wait(trap_wait),
        .link_we(link_we), .link_data(link_data)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sx9(input logic [15:0] w);
        return {{7{w[8]}}, w[8:0]};
    endfunction

    function automatic logic [15:0] sx11(input logic [15:0] w);
        return {{5{w[10]}}, w[10:0]};
    endfunction

    // One cycle: check registered state, drive, check outputs, advance model
    task automatic cyc(input logic st, input logic [15:0] ins, input logic [2:0] fl,
                       input logic [15:0] base, input logic [15:0] rd, input logic rv);
        logic acc;
        logic [3:0] op;
        logic [15:0] inc;
        @(negedge clk);
        chk(m_tag, pc, m_pc);
        chk("R8 wait flag", {15'd0, trap_wait}, {15'd0, m_wait});
        step = st; instr = ins; {flag_n, flag_z, flag_p} = fl;
        base_val = base; vec_rdata = rd; vec_rvalid = rv;
        #1;
        acc = st & ~m_wait;
        op  = ins[15:12];
        inc = m_pc + 16'd1;
        chk(m_wait ? "R8 link idle" : "R6 link strobe", {15'd0, link_we},
            {15'd0, acc && (op == 4'h4 || op == 4'hF)});
        if (acc && (op == 4'h4 || op == 4'hF)) chk("R6 link data", link_data, inc);
        chk(m_wait ? "R8 req idle" : "R7 req strobe", {15'd0, vec_req},
            {15'd0, acc && op == 4'hF});
        if (acc && op == 4'hF) chk("R7 req addr", vec_raddr, {8'h00, ins[7:0]});
        if (m_wait) begin
            if (rv) begin m_pc = rd; m_wait = 1'b0; m_tag = "R8 vector load"; end
            else m_tag = "R8 hold in wait";
        end else if (!st) begin
            m_tag = "R2 idle hold";
        end else begin
            case (op)
                4'h0: begin
                    m_tag = "R4 branch";
                    m_pc = (|(ins[11:9] & fl)) ? inc + sx9(ins) : inc;
                end
                4'hC: begin m_tag = "R5 jump"; m_pc = base; end
                4'h4: begin
                    m_tag = "R6 call";
                    m_pc = ins[11] ? inc + sx11(ins) : base;
                end
                4'hF: begin m_tag = "R7 trap hold"; m_wait = 1'b1; end
                default: begin m_tag = "R3 sequential"; m_pc = inc; end
            endcase
        end
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5E_ED01));
        rst_n = 1'b0; step = 1'b1; instr = 16'hC0C0; {flag_n, flag_z, flag_p} = 3'b111;
        base_val = 16'h1234; vec_rdata = 16'hAAAA; vec_rvalid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; step = 1'b0; vec_rvalid = 1'b0;
        #1;
        chk("R1 reset pc", pc, 16'h3000);
        chk("R1 reset wait", {15'd0, trap_wait}, 16'd0);
        chk("R1 reset link", {15'd0, link_we}, 16'd0);
        chk("R1 reset req", {15'd0, vec_req}, 16'd0);
        m_pc = 16'h3000; m_wait = 1'b0; m_tag = "R1 reset pc";

        cyc(1'b0, 16'hC0C0, 3'b111, 16'h1234, 16'h0, 1'b1); // R2 idle, stray rvalid
        cyc(1'b1, 16'h1234, 3'b000, 16'h0, 16'h0, 1'b0);     // R3 plain opcode
        cyc(1'b1, 16'h00FF, 3'b111, 16'h0, 16'h0, 1'b0);     // R4 empty mask
        cyc(1'b1, 16'h09FE, 3'b011, 16'h0, 16'h0, 1'b0);     // R4 n only, n clear
        cyc(1'b1, 16'h09FE, 3'b100, 16'h0, 16'h0, 1'b0);     // R4 n only, taken -2
        cyc(1'b1, 16'hC0C0, 3'b000, 16'hFFFE, 16'h0, 1'b0);  // R5 jump near top
        cyc(1'b1, 16'h0203, 3'b001, 16'h0, 16'h0, 1'b0);     // R9 wrap forward
        cyc(1'b1, 16'h4C00, 3'b000, 16'h0, 16'h0, 1'b0);     // R6 long -1024, R9
        cyc(1'b1, 16'h4080, 3'b000, 16'h4000, 16'h0, 1'b0);  // R6 register form
        cyc(1'b1, 16'hF0FF, 3'b000, 16'h0, 16'h0, 1'b0);     // R7 trap vector FF
        cyc(1'b1, 16'hC0C0, 3'b111, 16'h7777, 16'h0, 1'b0);  // R8 step in wait
        cyc(1'b1, 16'hF025, 3'b111, 16'h7777, 16'h0, 1'b0);  // R8 trap in wait
        cyc(1'b0, 16'h0000, 3'b000, 16'h0, 16'h0520, 1'b1);  // R8 data arrives
        cyc(1'b1, 16'hF020, 3'b000, 16'h0, 16'hBEEF, 1'b1);  // R7 rvalid same cycle
        cyc(1'b0, 16'h0000, 3'b000, 16'h0, 16'h0600, 1'b1);  // R8 load
        cyc(1'b0, 16'h0000, 3'b000, 16'h0, 16'h0, 1'b0);

        for (int i = 0; i < 4000; i++) begin
            logic [3:0] op;
            logic [31:0] r;
            r = $urandom;
            case (r[2:0])
                3'd0, 3'd1: op = 4'h0;
                3'd2: op = 4'hC;
                3'd3: op = 4'h4;
                3'd4: op = 4'hF;
                default: op = r[7:4];
            endcase
            cyc(r[8] | r[9], {op, r[21:10]}, r[24:22], $urandom, $urandom, r[25] & r[26]);
        end
        cyc(1'b0, 16'h0, 3'b000, 16'h0, 16'h0, 1'b1);
        cyc(1'b0, 16'h0, 3'b000, 16'h0, 16'h0, 1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule